// File: doc/BRIEF.md
# Register-Tested Branch and Link Unit

This block resolves control flow for a 32-bit load-store processor whose branches test the value held in a general register rather than a set of condition flags. During execute it receives the instruction word, the sequential PC (already advanced past the branch) and the two register operands the branch names. It then updates a registered program counter and can raise one register-file write request that saves the return address.

The jump target is always the full contents of a register, and the instruction carries no displacement. The condition looks at a second register. It can test whether that register is zero, nonzero, non-negative or negative, or it can be fixed as always or never. The linking form saves the sequential PC whether or not the jump is taken. Used with the "never" condition, it simply captures the current PC. Instructions that are not branches move the PC on sequentially. When execute holds no instruction, the PC keeps its value.

Top module: `branch_link_unit`

## Requirements
- R1: After a synchronous active-low reset, `pc_q` equals the `RESET_PC` parameter (default 0) and `link_we` is 0.
- R2: `rb_sel` equals `ex_instr[21:17]` and `rc_sel` equals `ex_instr[16:12]`, combinationally. The link destination is `ex_instr[26:22]`, the opcode is `ex_instr[31:27]` and the condition code is `ex_instr[2:0]`.
- R3: Opcode 8 (branch) and opcode 9 (branch-and-link) are branch instructions. Condition code 000 is never taken and condition code 001 is always taken.
- R4: Condition code 010 is taken when `rc_val` is zero. Condition code 011 is taken when `rc_val` is nonzero.
- R5: Condition code 100 is taken when bit 31 of `rc_val` is 0. Condition code 101 is taken when that bit is 1.
- R6: Condition codes 110 and 111 are never taken.
- R7: On the clock edge that accepts a valid branch, `pc_q` loads `rb_val` if the branch is taken and `ex_pc_seq` if it is not. The new value is visible after that edge.
- R8: A valid opcode 9 raises `link_we` for exactly the following cycle, with `link_addr` equal to the ra field and `link_data` equal to `ex_pc_seq`. This happens whether or not the branch is taken.
- R9: A valid opcode 8 and any valid opcode other than 8 or 9 leave `link_we` at 0. Any opcode other than 8 or 9 loads `pc_q` with `ex_pc_seq`.
- R10: When ra equals rb, the target is the `rb_val` presented with the instruction, not the link value being written.
- R11: While `ex_valid` is 0, `pc_q` holds its value and `link_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_valid | input | 1 | An instruction is present in execute |
| ex_instr | input | 32 | Instruction word |
| ex_pc_seq | input | 32 | Sequential PC, 4 past the branch |
| rb_val | input | 32 | Contents of register rb (target) |
| rc_val | input | 32 | Contents of register rc (tested value) |
| rb_sel | output | 5 | Read index for the target register |
| rc_sel | output | 5 | Read index for the tested register |
| pc_q | output | 32 | Registered program counter |
| link_we | output | 1 | Register-file write request for the link |
| link_addr | output | 5 | Link destination register |
| link_data | output | 32 | Saved return address |

## Verification
The bench tests each of the zero, nonzero and sign conditions with operands that do satisfy them and with operands that do not. A design with an inverted or swapped test would then jump when it should fall through. The sign tests use values that are negative but large, and nonzero but positive, so a design that compared against zero instead of looking at bit 31 lands on the wrong PC. The bench also uses link with "never" and with a false condition. A design that gated the write with the condition would then drop the return address. Reserved codes 110 and 111, a plain branch that must not write, a non-branch opcode, the ra equal to rb case and idle cycles catch designs that jump on reserved codes, write spuriously, use the link value as the target, or let the PC drift.

// File: rtl/branch_link_pkg.sv
// Shared encodings for the branch and link unit.
// Assumes the 5-bit opcode field at the top of a 32-bit instruction word.
package branch_link_pkg;
    localparam int OPW = 5;
    localparam int REGW = 5;
    localparam logic [OPW-1:0] OPC_BR  = 5'd8;
    localparam logic [OPW-1:0] OPC_BRL = 5'd9;

    typedef enum logic [2:0] {
        BC_NEVER   = 3'b000,
        BC_ALWAYS  = 3'b001,
        BC_ZERO    = 3'b010,
        BC_NONZERO = 3'b011,
        BC_POS     = 3'b100,
        BC_NEG     = 3'b101,
        BC_RSV6    = 3'b110,
        BC_RSV7    = 3'b111
    } bcond_e;
endpackage

// File: rtl/branch_field_decode.sv
// Splits a branch instruction word into its opcode, register and condition
// fields. The positions are fixed by the instruction format, and the unused
// middle of the modifier field is ignored.
module branch_field_decode
    import branch_link_pkg::*;
(
    input  logic [31:0]     instr,
    output logic [OPW-1:0]  op,
    output logic [REGW-1:0] ra,
    output logic [REGW-1:0] rb,
    output logic [REGW-1:0] rc,
    output bcond_e          cond
);
    logic unused_mod;

    // Field extraction
    always_comb begin
        op         = instr[31:27];
        ra         = instr[26:22];
        rb         = instr[21:17];
        rc         = instr[16:12];
        cond       = bcond_e'(instr[2:0]);
        unused_mod = ^instr[11:3];
    end
endmodule

// File: rtl/branch_cond_eval.sv
// Evaluates a branch condition against a register value.
// Assumes two's complement, so the sign is the top bit of the value.
module branch_cond_eval
    import branch_link_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  bcond_e          cond,
    input  logic [XLEN-1:0] value,
    output logic            hit
);
    logic is_zero;
    logic sign;

    assign is_zero = (value == '0);
    assign sign    = value[XLEN-1];

    // Condition selection; reserved codes never hit
    always_comb begin
        unique case (cond)
            BC_ALWAYS:  hit = 1'b1;
            BC_ZERO:    hit = is_zero;
            BC_NONZERO: hit = !is_zero;
            BC_POS:     hit = !sign;
            BC_NEG:     hit = sign;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_link_unit.sv
// Execute-stage branch resolution for a register-tested branch scheme.
// Opcode 8 jumps to rb_val when the condition on rc_val holds. Opcode 9 does
// the same and also requests a write of the sequential PC into ra, whatever
// the condition. Register reads are performed outside and are presented
// together with the instruction, so the target is always the pre-link value.
module branch_link_unit
    import branch_link_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ex_valid,
    input  logic [31:0]     ex_instr,
    input  logic [XLEN-1:0] ex_pc_seq,
    input  logic [XLEN-1:0] rb_val,
    input  logic [XLEN-1:0] rc_val,
    output logic [REGW-1:0] rb_sel,
    output logic [REGW-1:0] rc_sel,
    output logic [XLEN-1:0] pc_q,
    output logic            link_we,
    output logic [REGW-1:0] link_addr,
    output logic [XLEN-1:0] link_data
);
    logic [OPW-1:0]  op;
    logic [REGW-1:0] ra;
    bcond_e          cond;
    logic            cond_hit;
    logic            is_br;
    logic            is_brl;
    logic            take;
    logic [XLEN-1:0] pc_nxt;

    branch_field_decode u_dec (
        .instr (ex_instr),
        .op    (op),
        .ra    (ra),
        .rb    (rb_sel),
        .rc    (rc_sel),
        .cond  (cond)
    );

    branch_cond_eval #(.XLEN(XLEN)) u_cond (
        .cond  (cond),
        .value (rc_val),
        .hit   (cond_hit)
    );

    // Opcode classification and next-PC selection
    always_comb begin
        is_brl = (op == OPC_BRL);
        is_br  = (op == OPC_BR) || is_brl;
        take   = is_br && cond_hit;
        pc_nxt = take ? rb_val : ex_pc_seq;
    end

    // PC register: advances only on a valid instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= XLEN'(RESET_PC);
        end else if (ex_valid) begin
            pc_q <= pc_nxt;
        end
    end

    // Link write request, one cycle per valid branch-and-link
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_we   <= 1'b0;
            link_addr <= '0;
            link_data <= '0;
        end else begin
            link_we <= ex_valid && is_brl;
            if (ex_valid && is_brl) begin
                link_addr <= ra;
                link_data <= ex_pc_seq;
            end
        end
    end
endmodule

// File: rtl/branch_link_checker.sv
// Temporal checks on the branch and link unit, attached by bind.
module branch_link_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ex_valid,
    input logic [31:0]     ex_instr,
    input logic [XLEN-1:0] ex_pc_seq,
    input logic [XLEN-1:0] rb_val,
    input logic [XLEN-1:0] pc_q,
    input logic            link_we,
    input logic [4:0]      link_addr,
    input logic [XLEN-1:0] link_data
);
    logic [4:0] op_w;
    logic [2:0] cc_w;
    logic       br_any;
    assign op_w   = ex_instr[31:27];
    assign cc_w   = ex_instr[2:0];
    assign br_any = (op_w == 5'd8) || (op_w == 5'd9);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |=> ($stable(pc_q) && !link_we)); // R11

    AST_LINK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> $past(ex_valid && op_w == 5'd9)); // R9

    AST_LINK_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && op_w == 5'd9) |=> (link_we && link_data == $past(ex_pc_seq)
                                       && link_addr == $past(ex_instr[26:22]))); // R8

    AST_NONBRANCH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !br_any) |=> (pc_q == $past(ex_pc_seq))); // R9

    AST_RESERVED_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && br_any && (cc_w == 3'b110 || cc_w == 3'b111 || cc_w == 3'b000))
        |=> (pc_q == $past(ex_pc_seq))); // R6

    AST_ALWAYS_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && br_any && cc_w == 3'b001) |=> (pc_q == $past(rb_val))); // R3
endmodule

bind branch_link_unit branch_link_checker #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_valid  (ex_valid),
    .ex_instr  (ex_instr),
    .ex_pc_seq (ex_pc_seq),
    .rb_val    (rb_val),
    .pc_q      (pc_q),
    .link_we   (link_we),
    .link_addr (link_addr),
    .link_data (link_data)
);

// File: tb/tb_branch_link_unit.sv
module tb_branch_link_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_valid = 1'b0;
    logic [31:0] ex_instr = '0;
    logic [31:0] ex_pc_seq = '0;
    logic [31:0] rb_val = '0;
    logic [31:0] rc_val = '0;
    logic [4:0]  rb_sel, rc_sel, link_addr;
    logic [31:0] pc_q, link_data;
    logic        link_we;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    branch_link_unit dut (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_instr(ex_instr),
        .ex_pc_seq(ex_pc_seq), .rb_val(rb_val), .rc_val(rc_val),
        .rb_sel(rb_sel), .rc_sel(rc_sel), .pc_q(pc_q), .link_we(link_we),
        .link_addr(link_addr), .link_data(link_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] op, input logic [4:0] ra,
                                       input logic [4:0] rb, input logic [4:0] rc,
                                       input logic [2:0] cc);
        return {op, ra, rb, rc, 9'h0A5, cc};
    endfunction

    // Apply one valid instruction, then check PC and the link request after the edge
    task automatic run_one(input string req, input logic [31:0] ins, input logic [31:0] pcs,
                           input logic [31:0] rbv, input logic [31:0] rcv,
                           input logic [31:0] exp_pc, input bit exp_we);
        @(negedge clk);
        ex_valid = 1'b1; ex_instr = ins; ex_pc_seq = pcs; rb_val = rbv; rc_val = rcv;
        @(negedge clk);
        ex_valid = 1'b0;
        chk(pc_q == exp_pc, req, pc_q, exp_pc);
        chk(link_we == exp_we, req, {31'b0, link_we}, {31'b0, exp_we});
        if (exp_we) begin
            chk(link_data == pcs, req, link_data, pcs);
            chk(link_addr == ins[26:22], req, {27'b0, link_addr}, {27'b0, ins[26:22]});
        end
    endtask

    task automatic t_reset();
        chk(pc_q == 32'h0, "R1", pc_q, 32'h0);
        chk(link_we == 1'b0, "R1", {31'b0, link_we}, 32'h0);
    endtask

    task automatic t_fields();
        @(negedge clk);
        ex_instr = mk(5'd8, 5'd3, 5'd17, 5'd29, 3'b001);
        #1;
        chk(rb_sel == 5'd17, "R2 rb", {27'b0, rb_sel}, 32'd17);
        chk(rc_sel == 5'd29, "R2 rc", {27'b0, rc_sel}, 32'd29);
    endtask

    task automatic t_always_never();
        run_one("R3 always", mk(5'd8, 5'd0, 5'd4, 5'd1, 3'b001), 32'h104, 32'h2000, 32'h5, 32'h2000, 1'b0);
        run_one("R3 never",  mk(5'd8, 5'd0, 5'd4, 5'd1, 3'b000), 32'h204, 32'h2000, 32'h0, 32'h204, 1'b0);
    endtask

    task automatic t_zero_tests();
        run_one("R4 zr hit",  mk(5'd8, 5'd0, 5'd5, 5'd1, 3'b010), 32'h304, 32'h3000, 32'h0, 32'h3000, 1'b0);
        run_one("R4 zr miss", mk(5'd8, 5'd0, 5'd5, 5'd1, 3'b010), 32'h404, 32'h3000, 32'h1, 32'h404, 1'b0);
        run_one("R4 nz hit",  mk(5'd8, 5'd0, 5'd5, 5'd1, 3'b011), 32'h504, 32'h3100, 32'h80000000, 32'h3100, 1'b0);
        run_one("R4 nz miss", mk(5'd8, 5'd0, 5'd5, 5'd1, 3'b011), 32'h604, 32'h3100, 32'h0, 32'h604, 1'b0);
    endtask

    task automatic t_sign_tests();
        run_one("R5 pl zero",  mk(5'd8, 5'd0, 5'd6, 5'd2, 3'b100), 32'h704, 32'h4000, 32'h0, 32'h4000, 1'b0);
        run_one("R5 pl miss",  mk(5'd8, 5'd0, 5'd6, 5'd2, 3'b100), 32'h804, 32'h4000, 32'hFFFF_FFFF, 32'h804, 1'b0);
        run_one("R5 mi hit",   mk(5'd8, 5'd0, 5'd6, 5'd2, 3'b101), 32'h904, 32'h4100, 32'h8000_0001, 32'h4100, 1'b0);
        run_one("R5 mi miss",  mk(5'd8, 5'd0, 5'd6, 5'd2, 3'b101), 32'hA04, 32'h4100, 32'h7FFF_FFFF, 32'hA04, 1'b0);
    endtask

    task automatic t_reserved();
        run_one("R6 code110", mk(5'd8, 5'd0, 5'd7, 5'd3, 3'b110), 32'hB04, 32'h5000, 32'h0, 32'hB04, 1'b0);
        run_one("R6 code111", mk(5'd9, 5'd2, 5'd7, 5'd3, 3'b111), 32'hC04, 32'h5000, 32'hFFFF_FFFF, 32'hC04, 1'b1);
    endtask

    task automatic t_link();
        run_one("R8 never",    mk(5'd9, 5'd6, 5'd1, 5'd0, 3'b000), 32'hD04, 32'h6000, 32'h0, 32'hD04, 1'b1);
        run_one("R8 false",    mk(5'd9, 5'd12, 5'd1, 5'd0, 3'b010), 32'hE04, 32'h6000, 32'h9, 32'hE04, 1'b1);
        run_one("R7 R8 taken", mk(5'd9, 5'd31, 5'd1, 5'd0, 3'b011), 32'hF04, 32'h6100, 32'h9, 32'h6100, 1'b1);
        // link request lasts one cycle
        @(negedge clk);
        chk(link_we == 1'b0, "R8 pulse", {31'b0, link_we}, 32'h0);
    endtask

    task automatic t_same_reg();
        run_one("R10 ra==rb", mk(5'd9, 5'd4, 5'd4, 5'd0, 3'b001), 32'h1104, 32'h7000, 32'h0, 32'h7000, 1'b1);
    endtask

    task automatic t_nonbranch();
        run_one("R9 plain br", mk(5'd8, 5'd9, 5'd1, 5'd0, 3'b001), 32'h1204, 32'h7100, 32'h0, 32'h7100, 1'b0);
        run_one("R9 other op", mk(5'd12, 5'd3, 5'd1, 5'd0, 3'b001), 32'h1304, 32'h7200, 32'h0, 32'h1304, 1'b0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        ex_valid = 1'b0; ex_instr = mk(5'd9, 5'd1, 5'd1, 5'd0, 3'b001);
        ex_pc_seq = 32'hDEAD0000; rb_val = 32'hBEEF0000;
        @(negedge clk);
        @(negedge clk);
        chk(pc_q == 32'h1304, "R11 hold", pc_q, 32'h1304);
        chk(link_we == 1'b0, "R11 no write", {31'b0, link_we}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_always_never();
        t_zero_tests();
        t_sign_tests();
        t_reserved();
        t_link();
        t_same_reg();
        t_nonbranch();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule